// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block produces the 6-bit control word for a binary-weighted step attenuator with 0.5 dB resolution. The word can be written in two ways. In serial mode, a three-wire load shifts bits in on a data pin, clocked by a serial clock, and a latch-enable pin then moves them to the output. In parallel mode, a 6-bit bus drives the word. The bus is either latched by a pulse on the latch-enable pin or, while that pin stays high, passed straight through.

A mode pin selects serial (high) or parallel (low) operation. When reset is released, the block loads a start-up word, and the source of that word depends on the mode. In parallel mode with latch-enable low, two preset pins choose one of four fixed levels. In every other case the start-up word is taken from the parallel bus.

All external pins are asynchronous to the block. Each one passes through a two-flop synchronizer clocked by a fast system clock. The edges of the serial clock are found after synchronization. The result is held in a register and driven on `code_o`.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `rst` is high, `code_o` is 0.
- R2: `code_o` bit k weighs 0.5·2^k dB: bit 0 is 0.5 dB and bit 5 is 16 dB. All ones (63) is 31.5 dB and all zeros is the 0 dB reference.
- R3: Parallel mode with latch-enable low at reset release: preset pins {`preset_i[1]`,`preset_i[0]`} = 00, 01, 10, 11 give codes 0, 16, 32 and 62 (0, 8, 16 and 31 dB). The code appears after the first rising clock edge with `rst` low.
- R4: Parallel mode with latch-enable high at reset release: the start-up code is the value on `pbus_i`.
- R5: Serial mode at reset release: the start-up code is the value on `pbus_i`, whatever the latch-enable level.
- R6: Parallel mode with latch-enable held high: `code_o` follows `pbus_i`.
- R7: Parallel mode with latch-enable low: changes on `pbus_i` leave `code_o` unchanged. A low-high-low pulse on latch-enable loads the bus value.
- R8: Serial mode: `sdata_i` is captured on each rising edge of `sclk_i`, and the first bit captured lands in bit 5 (MSB first). When more than six bits are shifted, only the last six are kept.
- R9: Serial mode: while latch-enable is high, `code_o` takes the shift register contents. While latch-enable is low, `code_o` holds even when new bits are shifted in.
- R10: A change of `mode_i` while latch-enable is low leaves `code_o` unchanged.
- R11: A pin change that is set up before a rising clock edge reaches `code_o` at the third rising edge, counting that edge as the first, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least five times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset, held at least 3 cycles |
| mode_i | input | 1 | 1 = serial load, 0 = parallel load |
| sdata_i | input | 1 | Serial data |
| sclk_i | input | 1 | Serial shift clock |
| latch_i | input | 1 | Latch enable (serial transfer, parallel latch or transparent) |
| preset_i | input | 2 | Start-up level select for parallel mode |
| pbus_i | input | 6 | Parallel control word, also the start-up word in serial mode |
| code_o | output | 6 | Registered attenuation code |

## Verification
The assertions assume that every pin is steady for at least two system clocks around each serial clock edge and each latch-enable edge. They also assume that reset lasts long enough to fill the synchronizers, so that the synchronized mode, latch-enable and preset values are valid on the first cycle after release. The bench drives pins only on falling system-clock edges. It holds each serial clock phase for eight system cycles, and holds reset for four cycles with the start-up pins already in place. It keeps data and the bus steady across every latch-enable pulse.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;

  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } load_mode_e;

  localparam int unsigned STEPS_PER_DB = 2;

  // Start-up level in whole dB for a preset selection {hi, lo}
  function automatic int unsigned preset_db(input logic [1:0] sel);
    case (sel)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 31;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pin_sync_bank.sv
module pin_sync_bank #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) pipe[0] <= din;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) pipe[g] <= pipe[g-1];
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             init_load,
  input  logic [WIDTH-1:0] init_val,
  input  logic             sclk_s,
  input  logic             sdata_s,
  output logic             sclk_rise,
  output logic [WIDTH-1:0] shreg
);

  logic sclk_prev;

  always_ff @(posedge clk) sclk_prev <= sclk_s;

  assign sclk_rise = sclk_s & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (init_load) begin
      shreg <= init_val;
    end else if (enable && sclk_rise) begin
      shreg <= {shreg[WIDTH-2:0], sdata_s};
    end
  end

endmodule

// File: rtl/code_register.sv
module code_register
  import atten_ctrl_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  load_mode_e       mode_s,
  input  logic             latch_s,
  input  logic [1:0]       preset_s,
  input  logic [WIDTH-1:0] pbus_s,
  input  logic [WIDTH-1:0] shreg,
  output logic             init_pend,
  output logic [WIDTH-1:0] code_q
);

  logic [WIDTH-1:0] table_code;
  logic [WIDTH-1:0] startup_code;
  logic [WIDTH-1:0] load_src;

  always_comb begin
    table_code = WIDTH'(preset_db(preset_s) * STEPS_PER_DB);
    if (mode_s == MODE_SER || latch_s) startup_code = pbus_s;
    else                               startup_code = table_code;
    load_src = (mode_s == MODE_SER) ? shreg : pbus_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_pend <= 1'b1;
      code_q    <= '0;
    end else if (init_pend) begin
      init_pend <= 1'b0;
      code_q    <= startup_code;
    end else if (latch_s) begin
      code_q    <= load_src;
    end
  end

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_ctrl_pkg::*;
#(
  parameter int CODE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_i,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              latch_i,
  input  logic [1:0]        preset_i,
  input  logic [CODE_W-1:0] pbus_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int SYNC_W = CODE_W + 6;

  logic [SYNC_W-1:0] pins_s;
  logic              mode_bit_s, sdata_s, sclk_s, latch_s;
  logic [1:0]        preset_s;
  logic [CODE_W-1:0] pbus_s;
  load_mode_e        mode_s;
  logic              sclk_rise;
  logic [CODE_W-1:0] shreg;
  logic              init_pend;

  pin_sync_bank #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  ({pbus_i, preset_i, latch_i, sclk_i, sdata_i, mode_i}),
    .dout (pins_s)
  );

  assign {pbus_s, preset_s, latch_s, sclk_s, sdata_s, mode_bit_s} = pins_s;
  assign mode_s = load_mode_e'(mode_bit_s);

  serial_shifter #(.WIDTH(CODE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .enable    (mode_s == MODE_SER),
    .init_load (init_pend),
    .init_val  (pbus_s),
    .sclk_s    (sclk_s),
    .sdata_s   (sdata_s),
    .sclk_rise (sclk_rise),
    .shreg     (shreg)
  );

  code_register #(.WIDTH(CODE_W)) u_code (
    .clk       (clk),
    .rst       (rst),
    .mode_s    (mode_s),
    .latch_s   (latch_s),
    .preset_s  (preset_s),
    .pbus_s    (pbus_s),
    .shreg     (shreg),
    .init_pend (init_pend),
    .code_q    (code_o)
  );

endmodule

// File: rtl/step_atten_ctrl_chk.sv
module step_atten_ctrl_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_bit_s,
  input logic              latch_s,
  input logic [1:0]        preset_s,
  input logic [CODE_W-1:0] pbus_s,
  input logic              sclk_rise,
  input logic [CODE_W-1:0] shreg,
  input logic              init_pend,
  input logic [CODE_W-1:0] code_o
);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> code_o == '0);

  a_r3_preset_top: assert property (@(posedge clk) disable iff (rst)
    (init_pend && !mode_bit_s && !latch_s && preset_s == 2'b11) |=> code_o == CODE_W'(62));

  a_r5_serial_startup: assert property (@(posedge clk) disable iff (rst)
    (init_pend && mode_bit_s) |=> code_o == $past(pbus_s));

  a_r6_par_follow: assert property (@(posedge clk) disable iff (rst)
    (!init_pend && !mode_bit_s && latch_s) |=> code_o == $past(pbus_s));

  a_r7_hold_closed: assert property (@(posedge clk) disable iff (rst)
    (!init_pend && !latch_s) |=> $stable(code_o));

  a_r8_shift_only_on_edge: assert property (@(posedge clk) disable iff (rst)
    (!init_pend && !(sclk_rise && mode_bit_s)) |=> $stable(shreg));

  a_r9_serial_transfer: assert property (@(posedge clk) disable iff (rst)
    (!init_pend && mode_bit_s && latch_s) |=> code_o == $past(shreg));

endmodule

bind step_atten_ctrl step_atten_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_bit_s (mode_bit_s),
  .latch_s    (latch_s),
  .preset_s   (preset_s),
  .pbus_s     (pbus_s),
  .sclk_rise  (sclk_rise),
  .shreg      (shreg),
  .init_pend  (init_pend),
  .code_o     (code_o)
);

// File: tb/step_atten_ctrl_test.sv
module step_atten_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_i = 1'b0;
  logic       sdata_i = 1'b0;
  logic       sclk_i = 1'b0;
  logic       latch_i = 1'b0;
  logic [1:0] preset_i = 2'b00;
  logic [5:0] pbus_i = '0;
  logic [5:0] code_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  step_atten_ctrl uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .sdata_i(sdata_i), .sclk_i(sclk_i),
    .latch_i(latch_i), .preset_i(preset_i), .pbus_i(pbus_i), .code_o(code_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if (code_o !== exp) begin
      errors++;
      $display("FAIL %s: code_o=%0d expected=%0d", req, code_o, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic le, input logic [1:0] ps,
                          input logic [5:0] bus);
    @(negedge clk);
    rst = 1'b1; mode_i = m; latch_i = le; preset_i = ps; pbus_i = bus;
    sclk_i = 1'b0;
    cyc(4);
    check("R1", 6'd0);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic shift_bit(input logic b);
    sdata_i = b; sclk_i = 1'b0; cyc(8);
    sclk_i = 1'b1; cyc(8);
    sclk_i = 1'b0;
  endtask

  task automatic shift_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic le_pulse;
    cyc(4); latch_i = 1'b1; cyc(8); latch_i = 1'b0; cyc(6);
  endtask

  task automatic t_presets;
    do_reset(1'b0, 1'b0, 2'b00, 6'h2A); check("R3 sel00", 6'd0);
    do_reset(1'b0, 1'b0, 2'b01, 6'h2A); check("R3 sel01", 6'd16);
    do_reset(1'b0, 1'b0, 2'b10, 6'h2A); check("R3 sel10", 6'd32);
    do_reset(1'b0, 1'b0, 2'b11, 6'h2A); check("R3 sel11", 6'd62);
  endtask

  task automatic t_startup_bus;
    do_reset(1'b0, 1'b1, 2'b11, 6'h2B); check("R4", 6'h2B);
    do_reset(1'b1, 1'b0, 2'b11, 6'h15); check("R5 le low", 6'h15);
    do_reset(1'b1, 1'b1, 2'b01, 6'h07); check("R5 le high", 6'h07);
  endtask

  task automatic t_transparent;
    do_reset(1'b0, 1'b1, 2'b00, 6'h00);
    pbus_i = 6'h11; cyc(2); check("R11 not yet", 6'h00);
    cyc(1); check("R11 arrives", 6'h11);
    pbus_i = 6'h3C; cyc(4); check("R6 follow a", 6'h3C);
    pbus_i = 6'h01; cyc(4); check("R6 follow b", 6'h01);
  endtask

  task automatic t_latched;
    do_reset(1'b0, 1'b0, 2'b01, 6'h00);
    pbus_i = 6'h29; cyc(6); check("R7 hold", 6'd16);
    le_pulse; check("R7 pulse load", 6'h29);
    pbus_i = 6'h12; cyc(6); check("R7 hold after pulse", 6'h29);
  endtask

  task automatic t_serial;
    do_reset(1'b1, 1'b0, 2'b00, 6'h00);
    shift_word(6'b100101); cyc(4); check("R9 hold while shifting", 6'h00);
    le_pulse; check("R8 msb first", 6'b100101);
    shift_word(6'h3F); le_pulse; check("R2 all ones 31.5dB", 6'd63);
    shift_word(6'h00); le_pulse; check("R2 all zeros 0dB", 6'd0);
    shift_bit(1'b0); shift_bit(1'b1); shift_word(6'b011010);
    le_pulse; check("R8 last six kept", 6'b011010);
    shift_word(6'b000001); le_pulse; check("R2 lsb half dB", 6'd1);
  endtask

  task automatic t_mode_switch;
    do_reset(1'b1, 1'b0, 2'b00, 6'h0C);
    pbus_i = 6'h33; mode_i = 1'b0; cyc(6); check("R10 ser to par", 6'h0C);
    le_pulse; check("R10 par load after switch", 6'h33);
    mode_i = 1'b1; cyc(6); check("R10 par to ser", 6'h33);
  endtask

  initial begin
    t_presets;
    t_startup_bus;
    t_transparent;
    t_latched;
    t_serial;
    t_mode_switch;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule